// File: doc/BRIEF.md
# I2C-Controlled Video Crosspoint Controller

This block is the digital control side of a four-input, four-output analog video crosspoint. It listens on a two-wire I2C bus as a write-only slave. A transfer names the device, then a register index, then one or more data bytes. The block acknowledges every byte that belongs to it by pulling SDA low during the ninth clock.

The received bytes fill three control registers. These registers drive, for each of the four outputs, a one-hot input select, an output enable, and a x1/x2 gain choice. They also drive two clamp-control lines and two auxiliary logic lines that steer audio switching. The analog path itself is outside the block.

Three strap pins set the low bits of the device address, so up to seven controllers can share one bus. The strap value 111 removes the block from the bus and raises a flag that tells the surrounding logic that the crosspoint is under DC-voltage control.

The block has eight FSM states:
- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- SUB: shifting in the register index.
- SUB_ACK: acknowledging the index.
- DATA: shifting in a data byte.
- DATA_ACK: acknowledging a data byte.
- IGNORE: the traffic belongs to another device.

Its transitions are as follows:
- START moves any state to ADDR.
- STOP moves any state to IDLE.
- A matching write address moves ADDR to ADDR_ACK; any other address moves ADDR to IGNORE.
- Each ACK state leaves on the second SCL fall: ADDR_ACK goes to SUB, SUB_ACK goes to DATA, and DATA_ACK goes back to DATA.
- A completed byte moves SUB to SUB_ACK and DATA to DATA_ACK.
- Strap 111 holds the FSM in IDLE.

Top module: `vxp_ctrl`

## Requirements
- R1: The address byte is acknowledged (SDA held low during the ninth SCL pulse) only when its upper seven bits equal binary 1001 followed by strap[2:0], and its last bit is 0.
- R2: An address byte whose last (read/write) bit is 1 is not acknowledged, and the following bytes up to the next START or STOP are ignored.
- R3: An address byte that does not match is not acknowledged, and no register changes until a later matching frame.
- R4: With strap = 111, dc_mode is 1 and the block acknowledges no byte and changes no register. With any other strap value, dc_mode is 0.
- R5: After a matching address, the register index byte and every data byte are acknowledged. Each data byte goes to the current index, and the index then increments by one.
- R6: Index 0 holds the input selects. Bits [2k+1:2k] select the input for output k. Output k's select appears one-hot on sel_onehot[4k+3:4k], where bit i means input i.
- R7: Index 1 holds the gain and clamp controls. Bit k sets gain_x2[k] (1 = x2), and bits [5:4] set clamp_ctl[1:0].
- R8: Index 2 holds the enables and auxiliary lines. Bit k sets out_en[k] (1 = driving, 0 = high impedance), and bits [5:4] set aux[1:0]. No register changes without a received data byte.
- R9: A data byte aimed at an index of 3 or above is acknowledged and then discarded.
- R10: After reset, out_en = 0000, aux = 00, gain_x2 = 0000, clamp_ctl = 00, and every output selects input 0.
- R11: A repeated START, issued with no STOP after an ignored byte, restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| strap | input | 3 | Address strap pins; 111 selects DC-control mode |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| dc_mode | output | 1 | 1 = I2C response disabled by straps |
| sel_onehot | output | 16 | Per-output one-hot input select, 4 bits per output |
| out_en | output | 4 | Per-output driver enable, 0 = high impedance |
| gain_x2 | output | 4 | Per-output gain, 1 = x2 |
| clamp_ctl | output | 2 | Clamp-control lines |
| aux | output | 2 | Auxiliary logic lines for audio switching |

## Verification
Single-byte frames are sent to each of the three indices with distinct bit patterns. These separate the field placement of the selects, gains, clamps, enables and auxiliary bits. Multi-byte frames tell auto-increment apart from rewriting one register, and show that a byte landing past index 2 is discarded. Frames with a wrong address, a set read bit, an address repeated after a restart, a changed strap value and strap 111 separate address matching from acknowledgement of everything. Every frame ends with a comparison of the full control state against a bench model.

// File: rtl/vxp_pkg.sv
package vxp_pkg;
    localparam int NUM_OUT = 4;
    localparam int NUM_IN  = 4;
    localparam int SEL_W   = $clog2(NUM_IN);
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int CLAMP_W = 2;
    localparam int AUX_W   = 2;
    localparam logic [3:0]        ADDR_PREFIX = 4'b1001;
    localparam logic [BYTE_W-1:0] IDX_SEL  = 8'd0;
    localparam logic [BYTE_W-1:0] IDX_GAIN = 8'd1;
    localparam logic [BYTE_W-1:0] IDX_EN   = 8'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } i2c_state_e;
endpackage

// File: rtl/vxp_sync.sv
module vxp_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_V = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= {WIDTH{RST_V}};
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/vxp_i2c_slave.sv
module vxp_i2c_slave import vxp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [6:0]        dev_addr,
    input  logic              dc_mode,
    output logic              sda_pull,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    i2c_state_e        state_q, state_d;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] shreg_q, ptr_q;
    logic [2:0]        bitcnt_q;
    logic              ack_q;

    logic start_ev, stop_ev, scl_rise, scl_fall;
    logic rx_state, ack_state, byte_done, addr_hit;
    logic [BYTE_W-1:0] byte_in;

    assign start_ev  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_ev   = scl_s && scl_q && !sda_q && sda_s;
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);
    assign ack_state = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                       (state_q == ST_DATA_ACK);
    assign byte_in   = {shreg_q[BYTE_W-2:0], sda_s};
    assign byte_done = rx_state && scl_rise && (bitcnt_q == 3'd7);
    assign addr_hit  = (byte_in == {dev_addr, 1'b0});

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (dc_mode) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_SUB:      if (byte_done) state_d = ST_SUB_ACK;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_ADDR_ACK: if (scl_fall && ack_q) state_d = ST_SUB;
                ST_SUB_ACK:  if (scl_fall && ack_q) state_d = ST_DATA;
                ST_DATA_ACK: if (scl_fall && ack_q) state_d = ST_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            ptr_q    <= '0;
            ack_q    <= 1'b0;
            wr_valid <= 1'b0;
            wr_ptr   <= '0;
            wr_data  <= '0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            wr_valid <= 1'b0;
            if (dc_mode || start_ev || stop_ev) begin
                bitcnt_q <= '0;
                ack_q    <= 1'b0;
            end else begin
                if (rx_state && scl_rise) begin
                    shreg_q  <= byte_in;
                    bitcnt_q <= bitcnt_q + 3'd1;
                end
                if (ack_state && scl_fall) ack_q <= !ack_q;
                else if (!ack_state)       ack_q <= 1'b0;
                if (byte_done && state_q == ST_SUB) ptr_q <= byte_in;
                if (byte_done && state_q == ST_DATA) begin
                    wr_valid <= 1'b1;
                    wr_ptr   <= ptr_q;
                    wr_data  <= byte_in;
                    ptr_q    <= ptr_q + 8'd1;
                end
            end
        end
    end

    assign sda_pull = ack_q;
endmodule

// File: rtl/vxp_regs.sv
module vxp_regs import vxp_pkg::*; (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [BYTE_W-1:0]         wr_ptr,
    input  logic [BYTE_W-1:0]         wr_data,
    output logic [NUM_OUT*NUM_IN-1:0] sel_onehot,
    output logic [NUM_OUT-1:0]        out_en,
    output logic [NUM_OUT-1:0]        gain_x2,
    output logic [CLAMP_W-1:0]        clamp_ctl,
    output logic [AUX_W-1:0]          aux
);
    logic [NUM_OUT*SEL_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            out_en    <= '0;
            gain_x2   <= '0;
            clamp_ctl <= '0;
            aux       <= '0;
        end else if (wr_valid) begin
            case (wr_ptr)
                IDX_SEL:  sel_q <= wr_data[NUM_OUT*SEL_W-1:0];
                IDX_GAIN: begin
                    gain_x2   <= wr_data[NUM_OUT-1:0];
                    clamp_ctl <= wr_data[NUM_OUT +: CLAMP_W];
                end
                IDX_EN: begin
                    out_en <= wr_data[NUM_OUT-1:0];
                    aux    <= wr_data[NUM_OUT +: AUX_W];
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_dec
        assign sel_onehot[g*NUM_IN +: NUM_IN] = NUM_IN'(1) << sel_q[g*SEL_W +: SEL_W];
    end
endmodule

// File: rtl/vxp_ctrl.sv
module vxp_ctrl import vxp_pkg::*; (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic [STRAP_W-1:0]        strap,
    output logic                      sda_pull,
    output logic                      dc_mode,
    output logic [NUM_OUT*NUM_IN-1:0] sel_onehot,
    output logic [NUM_OUT-1:0]        out_en,
    output logic [NUM_OUT-1:0]        gain_x2,
    output logic [CLAMP_W-1:0]        clamp_ctl,
    output logic [AUX_W-1:0]          aux
);
    logic              scl_s, sda_s;
    logic              wr_valid;
    logic [BYTE_W-1:0] wr_ptr, wr_data;
    logic [6:0]        dev_addr;

    assign dev_addr = {ADDR_PREFIX, strap};
    assign dc_mode  = &strap;

    vxp_sync #(.WIDTH(2), .STAGES(2), .RST_V(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    vxp_i2c_slave u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .dev_addr (dev_addr),
        .dc_mode  (dc_mode),
        .sda_pull (sda_pull),
        .wr_valid (wr_valid),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data)
    );

    vxp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_ptr     (wr_ptr),
        .wr_data    (wr_data),
        .sel_onehot (sel_onehot),
        .out_en     (out_en),
        .gain_x2    (gain_x2),
        .clamp_ctl  (clamp_ctl),
        .aux        (aux)
    );
endmodule

// File: rtl/vxp_ctrl_chk.sv
module vxp_ctrl_chk import vxp_pkg::*; (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      scl_s,
    input logic                      sda_pull,
    input logic                      dc_mode,
    input logic                      wr_valid,
    input logic [BYTE_W-1:0]         wr_ptr,
    input logic [NUM_OUT*NUM_IN-1:0] sel_onehot,
    input logic [NUM_OUT-1:0]        out_en,
    input logic [NUM_OUT-1:0]        gain_x2,
    input logic [CLAMP_W-1:0]        clamp_ctl,
    input logic [AUX_W-1:0]          aux
);
    // R4
    dc_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_mode |=> !sda_pull);

    // R5
    ack_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    // R9
    undef_index_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ptr > IDX_EN) |=> ($stable(out_en) && $stable(aux) &&
        $stable(gain_x2) && $stable(clamp_ctl) && $stable(sel_onehot)));

    // R8
    regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(out_en) && $stable(aux)));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == '0 && aux == '0 && gain_x2 == '0));
endmodule

bind vxp_ctrl vxp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_pull   (sda_pull),
    .dc_mode    (dc_mode),
    .wr_valid   (wr_valid),
    .wr_ptr     (wr_ptr),
    .sel_onehot (sel_onehot),
    .out_en     (out_en),
    .gain_x2    (gain_x2),
    .clamp_ctl  (clamp_ctl),
    .aux        (aux)
);

// File: tb/vxp_ctrl_tb.sv
module vxp_ctrl_tb;
    import vxp_pkg::*;

    localparam int Q = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'd0;
    logic        sda_bus;
    logic        sda_pull, dc_mode;
    logic [15:0] sel_onehot;
    logic [3:0]  out_en, gain_x2;
    logic [1:0]  clamp_ctl, aux;

    assign sda_bus = sda_m & ~sda_pull;

    vxp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .strap(strap),
        .sda_pull(sda_pull), .dc_mode(dc_mode), .sel_onehot(sel_onehot),
        .out_en(out_en), .gain_x2(gain_x2), .clamp_ctl(clamp_ctl), .aux(aux)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string       tag_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];

    logic [1:0] m_sel [4];
    logic [3:0] m_gain = '0, m_en = '0;
    logic [1:0] m_clamp = '0, m_aux = '0;
    logic [7:0] dbuf [4];

    function automatic logic [31:0] model_snap();
        logic [15:0] oh = '0;
        for (int k = 0; k < 4; k++) oh[k*4 + int'(m_sel[k])] = 1'b1;
        return {3'b0, (strap == 3'b111), m_aux, m_clamp, m_gain, m_en, oh};
    endfunction

    function automatic logic [31:0] dut_snap();
        return {3'b0, dc_mode, aux, clamp_ctl, gain_x2, out_en, sel_onehot};
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic expect_item(input string t, input logic [31:0] v);
        tag_q.push_back(t);
        exp_q.push_back(v);
    endtask

    task automatic check_snap(input string t);
        expect_item(t, model_snap());
        act_q.push_back(dut_snap());
    endtask

    // monitor: pops expected items as results arrive
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [31:0] a, e;
                string t;
                a = act_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: result %h with no expected item", a);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (a !== e) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", t, a, e);
                    end
                end
            end
        end
    end

    task automatic apply_model(input logic [7:0] ptr, input logic [7:0] d);
        case (ptr)
            8'd0: for (int k = 0; k < 4; k++) m_sel[k] = d[2*k +: 2];
            8'd1: begin m_gain = d[3:0]; m_clamp = d[5:4]; end
            8'd2: begin m_en = d[3:0]; m_aux = d[5:4]; end
            default: ;
        endcase
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q();
            scl_m = 1'b0; wait_q();
        end
    endtask

    task automatic read_ack(output logic ak);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        ak = !sda_bus;
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_frame(input logic [6:0] a, input logic rw, input logic [7:0] sub,
                              input int n, input string tag);
        logic hit, ak;
        hit = (strap != 3'b111) && (a == {4'b1001, strap}) && !rw;
        bus_start();
        send_byte({a, rw});
        read_ack(ak);
        expect_item(tag, {31'b0, hit});
        act_q.push_back({31'b0, ak});
        if (hit) begin
            send_byte(sub);
            read_ack(ak);
            expect_item("R5", 32'd1);
            act_q.push_back({31'b0, ak});
            for (int i = 0; i < n; i++) begin
                send_byte(dbuf[i]);
                read_ack(ak);
                expect_item("R5", 32'd1);
                act_q.push_back({31'b0, ak});
                apply_model(sub + 8'(i), dbuf[i]);
            end
        end
        bus_stop();
        wait_q();
    endtask

    task automatic finish_run();
        done = 1'b1;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expected items never observed (actual 0 expected %0d)",
                     exp_q.size(), exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic ak;
        for (int k = 0; k < 4; k++) m_sel[k] = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_snap("R10");

        // R6: out0<-3, out1<-2, out2<-1, out3<-0
        dbuf[0] = 8'b00_01_10_11;
        send_frame(7'b1001000, 1'b0, 8'd0, 1, "R1");
        check_snap("R6");

        // R7: gains 1010, clamp 10
        dbuf[0] = 8'b0010_1010;
        send_frame(7'b1001000, 1'b0, 8'd1, 1, "R1");
        check_snap("R7");

        // R8: enables 0101, aux 11
        dbuf[0] = 8'b0011_0101;
        send_frame(7'b1001000, 1'b0, 8'd2, 1, "R1");
        check_snap("R8");

        // R5: auto-increment over all three indices
        dbuf[0] = 8'hE4; dbuf[1] = 8'h05; dbuf[2] = 8'h2F;
        send_frame(7'b1001000, 1'b0, 8'd0, 3, "R1");
        check_snap("R5");

        // R9: second byte lands on index 3, then a write to index 7
        dbuf[0] = 8'h0A; dbuf[1] = 8'hFF;
        send_frame(7'b1001000, 1'b0, 8'd2, 2, "R1");
        check_snap("R9");
        dbuf[0] = 8'h3F;
        send_frame(7'b1001000, 1'b0, 8'd7, 1, "R1");
        check_snap("R9");

        // R3: wrong address
        dbuf[0] = 8'hFF;
        send_frame(7'b1001011, 1'b0, 8'd2, 1, "R3");
        check_snap("R3");

        // R2: read bit set
        send_frame(7'b1001000, 1'b1, 8'd2, 1, "R2");
        check_snap("R2");

        // R11: ignored address, then a repeated START with a matching frame
        bus_start();
        send_byte({7'b1000000, 1'b0});
        read_ack(ak);
        expect_item("R11", 32'd0);
        act_q.push_back({31'b0, ak});
        dbuf[0] = 8'b0001_1100;
        send_frame(7'b1001000, 1'b0, 8'd1, 1, "R11");
        check_snap("R11");

        // R1: strap change moves the address
        strap = 3'd5;
        repeat (5) @(negedge clk);
        dbuf[0] = 8'b0010_1111;
        send_frame(7'b1001000, 1'b0, 8'd2, 1, "R1");
        send_frame(7'b1001101, 1'b0, 8'd2, 1, "R1");
        check_snap("R1");

        // R4: straps 111 disable the bus
        strap = 3'b111;
        repeat (5) @(negedge clk);
        check_snap("R4");
        dbuf[0] = 8'h00;
        send_frame(7'b1001111, 1'b0, 8'd2, 1, "R4");
        check_snap("R4");

        repeat (5) @(negedge clk);
        if (!done) finish_run();
    end
endmodule